// File: doc/BRIEF.md
# Segment Access Permission Checker

This block decides whether one memory access may go ahead under a cached segment descriptor. A request gives the offset into the segment, the access size in bytes, the kind of access, the current privilege level and a protected-mode enable. The descriptor side gives the base, the limit, the present bit, the descriptor privilege level, the selector's requested privilege level, the executable bit and the readable/writable bit.

One cycle after a valid request, the block shows a response strobe. The response carries either the linear address (base plus offset) or a fault code that names the fault to raise. Descriptor lookup, paging, fault delivery and the memory access itself belong to other blocks.

Control is a two-state machine. `ST_IDLE` moves to `ST_RESULT` on a cycle with `req_valid` high (transition REQ_ACCEPT). `ST_RESULT` stays in `ST_RESULT` on another request (transition REQ_CHAIN) and otherwise returns to `ST_IDLE` (transition RSP_DONE). `rsp_valid` is high exactly in `ST_RESULT`.

Top module: `seg_access_checker`

## Requirements
- R1: After reset, `rsp_valid` is 0, `rsp_fault` is 2'b00 and `rsp_linear` is 0.
- R2: A request sampled with `req_valid` high at a clock edge produces its response, with `rsp_valid` high, right after that edge. Back-to-back requests give back-to-back responses. With `req_valid` low, `rsp_valid` drops and `rsp_fault`/`rsp_linear` keep their last values whatever the inputs do.
- R3: If offset + size − 1 exceeds the limit, the fault is general-protection (2'b01). The sum is formed one bit wider than the address, so it never wraps. This check applies in both modes and wins over every other check.
- R4: With `pm_enable` low, the present, privilege and type checks are skipped; only the limit check and R11 apply.
- R5: With `pm_enable` high and the present bit clear, an access within the limit faults not-present (2'b10), ahead of the privilege and type checks.
- R6: A data read or write faults general-protection when RPL > DPL or when CPL > DPL.
- R7: An instruction fetch faults general-protection when CPL > DPL; RPL is not compared for fetches.
- R8: A fetch from a non-executable segment faults general-protection. A read from an executable segment with the readable bit clear faults general-protection. A read from a data segment is allowed whatever the writable bit holds.
- R9: Any write to an executable segment faults general-protection, and so does a write to a data segment whose writable bit is clear.
- R10: When no fault applies, `rsp_fault` is 2'b00 and `rsp_linear` is base + offset modulo 2^32. When a fault applies, `rsp_linear` is 0.
- R11: `req_kind` is encoded as 2'b00 fetch, 2'b01 data read and 2'b10 data write. The code 2'b11 faults general-protection in either mode once the limit check passes. `rsp_fault` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_offset | input | 32 | Offset into the segment |
| req_size | input | 3 | Access size in bytes (1 to 7) |
| req_kind | input | 2 | Access kind (see R11) |
| req_cpl | input | 2 | Current privilege level |
| pm_enable | input | 1 | Protected-mode enable |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 32 | Segment limit (last valid offset) |
| desc_present | input | 1 | Descriptor present bit |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_rpl | input | 2 | Requested privilege level of the selector |
| desc_exec | input | 1 | Executable (code) segment |
| desc_rw | input | 1 | Readable for code, writable for data |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 2 | 00 none, 01 general-protection, 10 not-present |
| rsp_linear | output | 32 | Linear address, 0 on fault |

## Verification
The hardest cases to reach are the ones where several faults apply at once. A non-present descriptor that is also overrun must report general-protection. A fetch whose RPL is worse than DPL must pass. A real-mode access to a non-present code segment being written must pass. The vector table builds each of these combinations on purpose, together with an end-of-segment overrun at the top of the 32-bit space that only the wide sum catches. Directed cycles then change every input while `req_valid` is low, to show that the held response stays put.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_RSVD  = 2'b11
    } access_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_GP   = 2'b01,
        FLT_NP   = 2'b10
    } fault_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] limit,
    output logic              over_limit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] end_excl;
    logic [EXT_W-1:0] bound_excl;

    // compare offset+size against limit+1 so no subtraction can underflow
    always_comb begin
        end_excl   = {1'b0, offset} + EXT_W'(size);
        bound_excl = {1'b0, limit} + EXT_W'(1);
        over_limit = end_excl > bound_excl;
    end
endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
    import seg_chk_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  access_kind_e      kind,
    input  logic [PRIV_W-1:0] cpl,
    input  logic [PRIV_W-1:0] dpl,
    input  logic [PRIV_W-1:0] rpl,
    input  logic              present,
    input  logic              exec,
    input  logic              rw,
    output logic              np_fault,
    output logic              gp_fault
);
    logic priv_bad;
    logic type_bad;

    always_comb begin
        np_fault = !present;
        priv_bad = 1'b0;
        type_bad = 1'b0;
        unique case (kind)
            KIND_FETCH: begin
                priv_bad = cpl > dpl;
                type_bad = !exec;
            end
            KIND_READ: begin
                priv_bad = (rpl > dpl) || (cpl > dpl);
                type_bad = exec && !rw;
            end
            KIND_WRITE: begin
                priv_bad = (rpl > dpl) || (cpl > dpl);
                type_bad = exec || !rw;
            end
            KIND_RSVD: begin
                type_bad = 1'b1;
            end
        endcase
        gp_fault = priv_bad || type_bad;
    end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3,
    parameter int PRIV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [1:0]        req_kind,
    input  logic [PRIV_W-1:0] req_cpl,
    input  logic              pm_enable,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [ADDR_W-1:0] desc_limit,
    input  logic              desc_present,
    input  logic [PRIV_W-1:0] desc_dpl,
    input  logic [PRIV_W-1:0] desc_rpl,
    input  logic              desc_exec,
    input  logic              desc_rw,
    output logic              rsp_valid,
    output logic [1:0]        rsp_fault,
    output logic [ADDR_W-1:0] rsp_linear
);
    localparam int EXT_W = ADDR_W + 1;

    access_kind_e      kind;
    logic              over_limit;
    logic              np_fault;
    logic              gp_fault;
    logic              rsvd_kind;
    fault_e            fault_d;
    logic [ADDR_W-1:0] linear_d;

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    fault_e            fault_q;
    logic [ADDR_W-1:0] linear_q;

    assign kind      = access_kind_e'(req_kind);
    assign rsvd_kind = (kind == KIND_RSVD);

    seg_limit_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_limit (
        .offset     (req_offset),
        .size       (req_size),
        .limit      (desc_limit),
        .over_limit (over_limit)
    );

    seg_prot_check #(.PRIV_W(PRIV_W)) u_prot (
        .kind     (kind),
        .cpl      (req_cpl),
        .dpl      (desc_dpl),
        .rpl      (desc_rpl),
        .present  (desc_present),
        .exec     (desc_exec),
        .rw       (desc_rw),
        .np_fault (np_fault),
        .gp_fault (gp_fault)
    );

    // priority: limit, reserved kind, not-present, privilege/type
    always_comb begin
        if (over_limit || rsvd_kind)
            fault_d = FLT_GP;
        else if (pm_enable && np_fault)
            fault_d = FLT_NP;
        else if (pm_enable && gp_fault)
            fault_d = FLT_GP;
        else
            fault_d = FLT_NONE;
        linear_d = (fault_d == FLT_NONE) ? desc_base + req_offset : '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_RESULT;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q  <= FLT_NONE;
            linear_q <= '0;
        end else if (req_valid) begin
            fault_q  <= fault_d;
            linear_q <= linear_d;
        end
    end

    assign rsp_valid  = (state_q == ST_RESULT);
    assign rsp_fault  = fault_q;
    assign rsp_linear = linear_q;

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_fault) && $stable(rsp_linear)));
    // R3
    limit_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (({1'b0, req_offset} + EXT_W'(req_size)) > ({1'b0, desc_limit} + EXT_W'(1))))
        |=> (rsp_fault == 2'b01));
    // R4
    real_mode_no_np_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pm_enable) |=> (rsp_fault != 2'b10));
    // R10
    fault_zero_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_linear == '0));
    // R11
    fault_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'b11);
endmodule

// File: tb/test_seg_access_checker.sv
`timescale 1ns/1ps
module test_seg_access_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_offset = '0;
    logic [2:0]  req_size = 3'd1;
    logic [1:0]  req_kind = 2'b00;
    logic [1:0]  req_cpl = '0;
    logic        pm_enable = 1'b0;
    logic [31:0] desc_base = '0;
    logic [31:0] desc_limit = '0;
    logic        desc_present = 1'b0;
    logic [1:0]  desc_dpl = '0;
    logic [1:0]  desc_rpl = '0;
    logic        desc_exec = 1'b0;
    logic        desc_rw = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_linear;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    seg_access_checker i_seg_access_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_size(req_size), .req_kind(req_kind), .req_cpl(req_cpl),
        .pm_enable(pm_enable), .desc_base(desc_base), .desc_limit(desc_limit),
        .desc_present(desc_present), .desc_dpl(desc_dpl), .desc_rpl(desc_rpl),
        .desc_exec(desc_exec), .desc_rw(desc_rw), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_linear(rsp_linear)
    );

    typedef struct packed {
        logic        pm;
        logic [1:0]  kind;
        logic [1:0]  cpl;
        logic        pres;
        logic [1:0]  dpl;
        logic [1:0]  rpl;
        logic        ex;
        logic        rw;
        logic [31:0] base;
        logic [31:0] lim;
        logic [31:0] off;
        logic [2:0]  size;
        logic [1:0]  fault;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    // kind: 00 fetch, 01 read, 10 write, 11 reserved; fault: 00 none, 01 GP, 10 NP
    localparam vec_t VEC [NV] = '{
        '{1'b1,2'b01,2'd0,1'b1,2'd0,2'd0,1'b0,1'b1,32'h1000_0000,32'h0000_FFFF,32'h0000_0010,3'd4,2'b00,4'd10}, // R10 plain read
        '{1'b1,2'b01,2'd0,1'b1,2'd0,2'd0,1'b0,1'b1,32'h1000_0000,32'h0000_FFFF,32'h0000_FFFD,3'd4,2'b01,4'd3},  // R3 one byte over
        '{1'b1,2'b01,2'd0,1'b1,2'd0,2'd0,1'b0,1'b1,32'h1000_0000,32'h0000_FFFF,32'h0000_FFFC,3'd4,2'b00,4'd3},  // R3 ends on limit
        '{1'b0,2'b01,2'd0,1'b1,2'd0,2'd0,1'b0,1'b1,32'h0000_0000,32'hFFFF_FFFF,32'hFFFF_FFFE,3'd4,2'b01,4'd3},  // R3 no wrap
        '{1'b0,2'b10,2'd3,1'b0,2'd0,2'd3,1'b1,1'b0,32'h2000_0000,32'h0000_FFFF,32'h0000_0100,3'd2,2'b00,4'd4},  // R4 real mode
        '{1'b1,2'b10,2'd3,1'b0,2'd0,2'd3,1'b1,1'b0,32'h2000_0000,32'h0000_FFFF,32'h0000_0100,3'd2,2'b10,4'd5},  // R5 NP first
        '{1'b1,2'b01,2'd0,1'b0,2'd0,2'd0,1'b0,1'b1,32'h2000_0000,32'h0000_00FF,32'h0000_0100,3'd1,2'b01,4'd3},  // R3 beats NP
        '{1'b1,2'b01,2'd0,1'b1,2'd2,2'd3,1'b0,1'b1,32'h1000_0000,32'h0000_FFFF,32'h0000_0020,3'd1,2'b01,4'd6},  // R6 rpl>dpl
        '{1'b1,2'b10,2'd3,1'b1,2'd2,2'd0,1'b0,1'b1,32'h1000_0000,32'h0000_FFFF,32'h0000_0020,3'd1,2'b01,4'd6},  // R6 cpl>dpl
        '{1'b1,2'b00,2'd0,1'b1,2'd0,2'd3,1'b1,1'b0,32'h0040_0000,32'h0000_FFFF,32'h0000_0200,3'd4,2'b00,4'd7},  // R7 rpl ignored
        '{1'b1,2'b00,2'd1,1'b1,2'd0,2'd0,1'b1,1'b1,32'h0040_0000,32'h0000_FFFF,32'h0000_0200,3'd4,2'b01,4'd7},  // R7 cpl>dpl
        '{1'b1,2'b00,2'd0,1'b1,2'd0,2'd0,1'b0,1'b1,32'h0040_0000,32'h0000_FFFF,32'h0000_0200,3'd4,2'b01,4'd8},  // R8 fetch data seg
        '{1'b1,2'b01,2'd0,1'b1,2'd0,2'd0,1'b1,1'b0,32'h0040_0000,32'h0000_FFFF,32'h0000_0200,3'd4,2'b01,4'd8},  // R8 exec unreadable
        '{1'b1,2'b01,2'd0,1'b1,2'd0,2'd0,1'b1,1'b1,32'h0040_0000,32'h0000_FFFF,32'h0000_0204,3'd4,2'b00,4'd8},  // R8 exec readable
        '{1'b1,2'b01,2'd0,1'b1,2'd0,2'd0,1'b0,1'b0,32'h0040_0000,32'h0000_FFFF,32'h0000_0208,3'd4,2'b00,4'd8},  // R8 read ro data
        '{1'b1,2'b10,2'd0,1'b1,2'd0,2'd0,1'b1,1'b1,32'h0040_0000,32'h0000_FFFF,32'h0000_0200,3'd4,2'b01,4'd9},  // R9 write code
        '{1'b1,2'b10,2'd0,1'b1,2'd0,2'd0,1'b0,1'b0,32'h0040_0000,32'h0000_FFFF,32'h0000_0200,3'd4,2'b01,4'd9},  // R9 write ro data
        '{1'b1,2'b10,2'd2,1'b1,2'd3,2'd3,1'b0,1'b1,32'h0040_0000,32'h0000_FFFF,32'h0000_0300,3'd4,2'b00,4'd9},  // R9 write ok
        '{1'b1,2'b11,2'd0,1'b1,2'd0,2'd0,1'b0,1'b1,32'h0040_0000,32'h0000_FFFF,32'h0000_0300,3'd1,2'b01,4'd11}, // R11 reserved pm
        '{1'b1,2'b01,2'd0,1'b1,2'd0,2'd0,1'b0,1'b1,32'hFFFF_FFF0,32'h0000_FFFF,32'h0000_0020,3'd1,2'b00,4'd10}, // R10 wraps mod 2^32
        '{1'b0,2'b11,2'd0,1'b1,2'd0,2'd0,1'b0,1'b1,32'h0040_0000,32'h0000_FFFF,32'h0000_0300,3'd1,2'b01,4'd11}  // R11 reserved real
    };

    task automatic check(input string tag, input logic [1:0] ef, input logic [31:0] el, input logic ev);
        checks++;
        if (rsp_fault !== ef || rsp_linear !== el || rsp_valid !== ev) begin
            fails++;
            $display("FAIL %s: valid=%0b fault=%0b linear=%h expected valid=%0b fault=%0b linear=%h",
                     tag, rsp_valid, rsp_fault, rsp_linear, ev, ef, el);
        end
    endtask

    task automatic apply(input vec_t v);
        pm_enable = v.pm; req_kind = v.kind; req_cpl = v.cpl; desc_present = v.pres;
        desc_dpl = v.dpl; desc_rpl = v.rpl; desc_exec = v.ex; desc_rw = v.rw;
        desc_base = v.base; desc_limit = v.lim; req_offset = v.off; req_size = v.size;
    endtask

    function automatic logic [31:0] exp_lin(input vec_t v);
        return (v.fault == 2'b00) ? v.base + v.off : 32'h0;
    endfunction

    initial begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 2'b00, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 2'b00, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].fault, exp_lin(VEC[i]), 1'b1);
            @(negedge clk);
        end

        // R2 hold: change everything with req_valid low
        apply(VEC[0]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 response", 2'b00, 32'h1000_0010, 1'b1);
        apply(VEC[5]);
        @(negedge clk);
        check("R2 held while idle", 2'b00, 32'h1000_0010, 1'b0);
        @(negedge clk);
        check("R2 still held", 2'b00, 32'h1000_0010, 1'b0);

        // R2 back-to-back
        apply(VEC[5]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R2 first of pair", 2'b10, 32'h0, 1'b1);
        apply(VEC[9]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 second of pair", 2'b00, 32'h0040_0200, 1'b1);
        @(negedge clk);
        check("R2 strobe drops", 2'b00, 32'h0040_0200, 1'b0);

        // R1 reset mid-stream clears the response
        apply(VEC[1]);
        req_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 reset clears", 2'b00, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule